// File: doc/BRIEF.md
# Flag-Setting Arithmetic Unit with Condition Register

This block is a 64-bit arithmetic and logic unit that adds, subtracts or bitwise-ANDs two operands and presents the result combinationally. Next to the datapath sits a four-bit condition register holding negative, zero, carry and overflow flags. That register is architectural state: it is written only when the set-flags control accompanies the operation, matching the flag-setting instruction forms, and otherwise keeps its contents across any number of operations.

In a pipeline the unit sits in the execute stage. The decoder drives the operation select and raises the set-flags control for the flag-setting variants. Register and immediate forms look the same here because the operand arrives already selected. Branch logic reads the stored flags in a later cycle. The flags follow an active-low asynchronous reset to all zeros.

Top module: `cc_alu`

## Requirements
- R1: With op_sel = 2'b00 the result equals opnd_a + opnd_b modulo 2^64, in the same cycle as the inputs.
- R2: With op_sel = 2'b01 the result equals opnd_a + ~opnd_b + 1 modulo 2^64, that is opnd_a minus opnd_b.
- R3: With op_sel[1] = 1 (codes 2'b10 and 2'b11) the result equals opnd_a & opnd_b.
- R4: While rst_n is low, all four flags read 0, whatever the clock does.
- R5: On a rising clock edge with set_flags high the flags take the values computed from that cycle's operation. With set_flags low they keep their previous values.
- R6: The stored N flag equals bit 63 of the result of the flag-setting operation.
- R7: The stored Z flag is 1 exactly when that result is all zeros.
- R8: For add, the stored C flag is the carry out of bit 63. For subtract, C is the carry out of opnd_a + ~opnd_b + 1, so C = 1 means no borrow (opnd_a >= opnd_b unsigned).
- R9: For add and subtract, the stored V flag is 1 when the operation overflows as signed two's-complement arithmetic.
- R10: A flag-setting AND stores C = 0 and V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| op_sel | input | 2 | 00 add, 01 subtract, 1x AND |
| set_flags | input | 1 | Write the flags at the next rising edge |
| result | output | 64 | Combinational operation result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The vector set covers the following operand patterns:
- Small positive sums, which leave every flag clear.
- An all-ones plus one, which isolates carry and zero from overflow.
- A largest-positive plus one, which gives signed overflow without carry.
- Two most-negative values added, which raise carry, overflow and zero together.

Subtraction is tried with equal operands, with a smaller minuend and across the most-negative boundary. These cases separate the no-borrow meaning of carry from a borrow flag and check overflow on subtraction. AND patterns with a set top bit and a zero result cover both encodings of the AND code. Directed sequences then check that the flags hold when set-flags is low, that a flag-setting AND clears previously set carry and overflow, and that reset clears the flags in the middle of a run.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

    // Both 1x codes select AND
    function automatic alu_op_e decode_op(input logic [1:0] code);
        alu_op_e op;
        unique case (code)
            2'b00:   op = OP_ADD;
            2'b01:   op = OP_SUB;
            default: op = OP_AND;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff     = b ^ {WIDTH{sub}};
        wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum       = wide[WIDTH-1:0];
        carry_out = wide[WIDTH];
        ovf       = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             carry_out,
    input  logic             ovf,
    output cond_flags_t      next_flags
);
    always_comb begin
        next_flags.n = res[WIDTH-1];
        next_flags.z = (res == '0);
        unique case (op)
            OP_ADD, OP_SUB: begin
                next_flags.c = carry_out;
                next_flags.v = ovf;
            end
            default: begin
                next_flags.c = 1'b0;
                next_flags.v = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  cond_flags_t d,
    output cond_flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [1:0]       op_sel,
    input  logic             set_flags,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    alu_op_e          op;
    logic [WIDTH-1:0] arith_sum;
    logic             arith_c;
    logic             arith_v;
    cond_flags_t      flags_d;
    cond_flags_t      flags_q;

    assign op = decode_op(op_sel);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (op == OP_SUB),
        .sum       (arith_sum),
        .carry_out (arith_c),
        .ovf       (arith_v)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: result = arith_sum;
            default:        result = opnd_a & opnd_b;
        endcase
    end

    alu_flag_gen #(.WIDTH(WIDTH)) u_fgen (
        .op         (op),
        .res        (result),
        .carry_out  (arith_c),
        .ovf        (arith_v),
        .next_flags (flags_d)
    );

    alu_flag_reg u_freg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (set_flags),
        .d     (flags_d),
        .q     (flags_q)
    );

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;
endmodule

// File: rtl/cc_alu_sva.sv
module cc_alu_sva #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [1:0]       op_sel,
    input logic             set_flags,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v
);
    p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b00) |-> (result == opnd_a + opnd_b));

    p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 2'b01) |-> (result == opnd_a - opnd_b));

    p_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel[1] |-> (result == (opnd_a & opnd_b)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    p_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_n == $past(result[WIDTH-1])));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_z == ($past(result) == '0)));

    p_and_cv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_sel[1]) |=> (!flag_c && !flag_v));
endmodule

bind cc_alu cc_alu_sva #(.WIDTH(WIDTH)) u_sva (.*);

// File: tb/sim_cc_alu.sv
module sim_cc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [1:0]  op_sel = 2'b00;
    logic        set_flags = 1'b0;
    logic [63:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cc_alu u0 (.*);

    // {op[197:196], a[195:132], b[131:68], result[67:4], nzcv[3:0]}
    localparam int NV = 9;
    localparam logic [197:0] VEC [NV] = '{
        {2'b00, 64'd1, 64'd2, 64'd3, 4'b0000},
        {2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 4'b0110},
        {2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'h8000_0000_0000_0000, 4'b1001},
        {2'b01, 64'd5, 64'd5, 64'd0, 4'b0110},
        {2'b01, 64'd3, 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 4'b1000},
        {2'b01, 64'h8000_0000_0000_0000, 64'd1, 64'h7FFF_FFFF_FFFF_FFFF, 4'b0011},
        {2'b10, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'hF000_F000_F000_F000, 4'b1000},
        {2'b11, 64'h0F, 64'hF0, 64'd0, 4'b0100},
        {2'b00, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 4'b0111}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [63:0] a,
                         input logic [63:0] b, input logic sf);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; set_flags = sf;
    endtask

    function automatic logic [3:0] nzcv();
        return {flag_n, flag_z, flag_c, flag_v};
    endfunction

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R4 flags in reset", {60'd0, nzcv()}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][197:196], VEC[i][195:132], VEC[i][131:68], 1'b1);
            #1;
            check(VEC[i][197] ? "R3 and result" :
                  (VEC[i][196] ? "R2 sub result" : "R1 add result"),
                  result, VEC[i][67:4]);
            @(posedge clk); #1;
            check("R5 R6 R7 R8 R9 R10 flags", {60'd0, nzcv()}, {60'd0, VEC[i][3:0]});
        end

        // flags now 0111; a non-flag-setting add must leave them
        apply(2'b00, 64'd1, 64'd2, 1'b0);
        @(posedge clk); #1;
        check("R5 hold without set_flags", {60'd0, nzcv()}, 64'h7);
        apply(2'b01, 64'd0, 64'd1, 1'b0);
        @(posedge clk); #1;
        check("R5 hold second op", {60'd0, nzcv()}, 64'h7);

        // flag-setting AND clears C and V set earlier
        apply(2'b10, 64'd1, 64'd1, 1'b1);
        @(posedge clk); #1;
        check("R10 and clears C V", {60'd0, nzcv()}, 64'h0);

        // set N and V, then reset mid-run
        apply(2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b1);
        @(posedge clk); #1;
        check("R9 overflow set", {60'd0, nzcv()}, 64'h9);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R4 async clear", {60'd0, nzcv()}, 64'h0);
        @(posedge clk); #1;
        check("R4 held in reset", {60'd0, nzcv()}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        set_flags = 1'b0;
        @(posedge clk); #1;
        check("R4 R5 after reset release", {60'd0, nzcv()}, 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule